// File: doc/BRIEF.md
# Banked Scratchpad Conflict Serializer

This block is a 16 KB on-chip scratchpad built from 16 independent banks of 32-bit words. A group of 16 lanes presents one read or one write at a time. Each lane has its own word address, write data and an active bit. The block works out which bank each lane needs. Lanes whose banks differ are served together. Lanes that land on the same bank are served one after another, so each bank handles at most one address per clock. Every lane's read result is kept in its own output register, and a single-cycle done pulse closes the group.

Some groups skip the serialization. When every active lane names the same word, that word is read once and given to all of them, or written once, in a single cycle. Only one group is handled at a time: a busy flag is raised when a group is taken, and new requests are ignored until the group ends. A parameter can remove the broadcast path; the default keeps it.

Top module: `sp_conflict_serializer`

## Requirements
- R1: A 12-bit word address selects bank = address bits [3:0] and row = address bits [11:4]. Each lane's read returns the word most recently written at its own address, on that lane's 32-bit slice of rd_data (lane t uses bits [32t+31:32t]).
- R2: When the active lanes of a group all use different banks, done is high in the cycle that follows the first rising edge after the edge that took the group.
- R3: When every active lane names the same word, the group completes as for R2, in one service cycle, and every active lane receives that word.
- R4: In all other cases done follows the K-th rising edge after acceptance. K is the largest number of active lanes mapped to any one bank, and lanes sharing a word count separately, so stride 2 gives K=2 and stride 8 gives K=8.
- R5: A lane whose req_mask bit is 0 takes no bank slot, writes nothing and leaves its rd_data slice unchanged. A group with no active lane completes after one service cycle.
- R6: In the broadcast case of a write, the word takes the data of the highest-indexed active lane.
- R7: busy is high from the cycle after acceptance until done. A req_valid seen while busy is high is ignored: it performs no access and starts no group.
- R8: done is high for exactly one cycle, and busy is low in that cycle.
- R9: After reset, busy and done are low and rd_data is all zero.
- R10: Within one bank, conflicting lanes are served in ascending lane order. When several lanes write one word in a group that is not uniform, the highest-indexed lane's data remains.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Offer a group; taken on a rising edge when busy is low |
| req_write | input | 1 | 1 = write group, 0 = read group |
| req_mask | input | 16 | Per-lane active bits |
| req_addr | input | 192 | Per-lane 12-bit word addresses, lane t at [12t+11:12t] |
| req_wdata | input | 512 | Per-lane write data, lane t at [32t+31:32t] |
| busy | output | 1 | A group is in service |
| done | output | 1 | One-cycle pulse after the last access of a group |
| rd_data | output | 512 | Per-lane read result registers |

## Verification
The hardest situation to reach from the ports is a spurious request arriving in the middle of a multi-cycle group. To create it, the bench starts a stride-8 read and keeps req_valid high with different write data for several service cycles. It drops the request before the cycle in which busy falls. It then reads the targeted words back and compares them with its model. The bench predicts the cycle cost of each group from its own per-bank lane counts over sweeps of strides, bases, permutations and masks. It also checks ordering through overlapping writes to one word, once in a uniform group and once in a group that is not uniform.

// File: rtl/sp_pkg.sv
`timescale 1ns/1ps
package sp_pkg;

   typedef enum logic {
      SP_READ  = 1'b0,
      SP_WRITE = 1'b1
   } sp_op_e;

   function automatic bit sp_is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/sp_bank.sv
`timescale 1ns/1ps
module sp_bank #(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 256,
   localparam int ROW_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ROW_W-1:0]  row,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[row] <= wdata;
   end

   assign rdata = mem[row];

endmodule

// File: rtl/sp_pick.sv
`timescale 1ns/1ps
module sp_pick #(
   parameter int N  = 16,
   localparam int IW = $clog2(N)
) (
   input  logic [N-1:0]  req,
   output logic [IW-1:0] lo_idx,
   output logic [IW-1:0] hi_idx,
   output logic          any
);

   always_comb begin
      lo_idx = '0;
      hi_idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) lo_idx = IW'(i);
      end
      for (int i = 0; i < N; i++) begin
         if (req[i]) hi_idx = IW'(i);
      end
      any = |req;
   end

endmodule

// File: rtl/sp_conflict_serializer.sv
`timescale 1ns/1ps
module sp_conflict_serializer
   import sp_pkg::*;
#(
   parameter int LANES      = 16,
   parameter int BANKS      = 16,
   parameter int DATA_W     = 32,
   parameter int BANK_DEPTH = 256,
   parameter bit BCAST_EN   = 1'b1,
   localparam int BANK_W = $clog2(BANKS),
   localparam int ROW_W  = $clog2(BANK_DEPTH),
   localparam int ADDR_W = BANK_W + ROW_W,
   localparam int LANE_W = $clog2(LANES)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     req_valid,
   input  logic                     req_write,
   input  logic [LANES-1:0]         req_mask,
   input  logic [LANES*ADDR_W-1:0]  req_addr,
   input  logic [LANES*DATA_W-1:0]  req_wdata,
   output logic                     busy,
   output logic                     done,
   output logic [LANES*DATA_W-1:0]  rd_data
);

   if (!sp_is_pow2(BANKS))      begin : g_chk_banks $error("BANKS must be a power of two"); end
   if (!sp_is_pow2(BANK_DEPTH)) begin : g_chk_depth $error("BANK_DEPTH must be a power of two"); end
   if (LANES < 2)               begin : g_chk_lanes $error("LANES must be at least 2"); end

   logic [ADDR_W-1:0] in_addr [LANES];
   logic [DATA_W-1:0] in_wd   [LANES];
   logic              uni_in;

   always_comb begin
      for (int t = 0; t < LANES; t++) begin
         in_addr[t] = req_addr[t*ADDR_W +: ADDR_W];
         in_wd[t]   = req_wdata[t*DATA_W +: DATA_W];
      end
   end

   if (BCAST_EN) begin : g_bcast
      logic [ADDR_W-1:0] ref_addr;
      always_comb begin
         ref_addr = '0;
         for (int t = LANES - 1; t >= 0; t--) begin
            if (req_mask[t]) ref_addr = in_addr[t];
         end
         uni_in = 1'b1;
         for (int t = 0; t < LANES; t++) begin
            if (req_mask[t] && (in_addr[t] != ref_addr)) uni_in = 1'b0;
         end
      end
   end else begin : g_no_bcast
      assign uni_in = 1'b0;
   end

   logic              busy_q, done_q, uni_q;
   sp_op_e            wr_q;
   logic [LANES-1:0]  pend_q;
   logic [ADDR_W-1:0] addr_q [LANES];
   logic [DATA_W-1:0] wdat_q [LANES];
   logic [DATA_W-1:0] rdat_q [LANES];

   logic [BANK_W-1:0] bank_of [LANES];
   logic [LANES-1:0]  hit     [BANKS];
   logic [LANE_W-1:0] lo_idx  [BANKS];
   logic [LANE_W-1:0] hi_idx  [BANKS];
   logic [LANE_W-1:0] sel_idx [BANKS];
   logic [BANKS-1:0]  bank_any;
   logic [DATA_W-1:0] bank_rd [BANKS];
   logic [LANES-1:0]  served;
   logic [LANES-1:0]  pend_nx;

   always_comb begin
      for (int t = 0; t < LANES; t++) bank_of[t] = addr_q[t][BANK_W-1:0];
   end

   for (genvar b = 0; b < BANKS; b++) begin : g_bank
      always_comb begin
         for (int t = 0; t < LANES; t++) begin
            hit[b][t] = pend_q[t] && (bank_of[t] == BANK_W'(b));
         end
      end

      sp_pick #(.N(LANES)) i_pick (
         .req    (hit[b]),
         .lo_idx (lo_idx[b]),
         .hi_idx (hi_idx[b]),
         .any    (bank_any[b])
      );

      assign sel_idx[b] = (uni_q && (wr_q == SP_WRITE)) ? hi_idx[b] : lo_idx[b];

      sp_bank #(.DATA_W(DATA_W), .DEPTH(BANK_DEPTH)) i_bank (
         .clk   (clk),
         .we    (busy_q && bank_any[b] && (wr_q == SP_WRITE)),
         .row   (addr_q[sel_idx[b]][ADDR_W-1:BANK_W]),
         .wdata (wdat_q[sel_idx[b]]),
         .rdata (bank_rd[b])
      );
   end

   always_comb begin
      for (int t = 0; t < LANES; t++) begin
         served[t] = pend_q[t] && (uni_q || (lo_idx[bank_of[t]] == LANE_W'(t)));
      end
      pend_nx = pend_q & ~served;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         done_q <= 1'b0;
         uni_q  <= 1'b0;
         wr_q   <= SP_READ;
         pend_q <= '0;
         for (int t = 0; t < LANES; t++) begin
            addr_q[t] <= '0;
            wdat_q[t] <= '0;
            rdat_q[t] <= '0;
         end
      end else begin
         done_q <= 1'b0;
         if (!busy_q) begin
            if (req_valid) begin
               busy_q <= 1'b1;
               pend_q <= req_mask;
               wr_q   <= sp_op_e'(req_write);
               uni_q  <= uni_in;
               for (int t = 0; t < LANES; t++) begin
                  addr_q[t] <= in_addr[t];
                  wdat_q[t] <= in_wd[t];
               end
            end
         end else begin
            pend_q <= pend_nx;
            for (int t = 0; t < LANES; t++) begin
               if (served[t] && (wr_q == SP_READ)) rdat_q[t] <= bank_rd[bank_of[t]];
            end
            if (pend_nx == '0) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
            end
         end
      end
   end

   always_comb begin
      for (int t = 0; t < LANES; t++) rd_data[t*DATA_W +: DATA_W] = rdat_q[t];
   end

   assign busy = busy_q;
   assign done = done_q;

endmodule

// File: rtl/sp_checker.sv
`timescale 1ns/1ps
module sp_checker #(
   parameter int LANES = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_valid,
   input logic             busy,
   input logic             done,
   input logic [LANES-1:0] pend,
   input logic             uni
);

   p_done_ends_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy)));

   p_busy_until_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);

   p_idle_ignores_nothing_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !req_valid) |=> !busy);

   p_no_new_pending_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> ((pend & ~$past(pend)) == '0));

   p_broadcast_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && uni) |=> !busy);

   p_progress_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && (pend != '0)) |=> (!busy || ($countones(pend) < $past($countones(pend)))));

endmodule

bind sp_conflict_serializer sp_checker #(.LANES(LANES)) i_sp_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .busy      (busy),
   .done      (done),
   .pend      (pend_q),
   .uni       (uni_q)
);

// File: tb/test_sp_conflict_serializer.sv
`timescale 1ns/1ps
module test_sp_conflict_serializer;

   localparam int L  = 16;
   localparam int AW = 12;
   localparam int DW = 32;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            req_valid = 1'b0;
   logic            req_write = 1'b0;
   logic [L-1:0]    req_mask = '0;
   logic [L*AW-1:0] req_addr = '0;
   logic [L*DW-1:0] req_wdata = '0;
   logic            busy, done;
   logic [L*DW-1:0] rd_data;

   always #4 clk = ~clk;

   sp_conflict_serializer i_sp_conflict_serializer (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_mask(req_mask), .req_addr(req_addr), .req_wdata(req_wdata),
      .busy(busy), .done(done), .rd_data(rd_data)
   );

   int checks = 0;
   int fails  = 0;
   logic [DW-1:0] model  [4096];
   logic [DW-1:0] exp_rd [L];
   logic [AW-1:0] g_addr [L];
   logic [DW-1:0] g_data [L];
   int unsigned   seed = 32'h1234_5678;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] hv(input int a, input int salt);
      return (a * 32'h9E37_79B1) ^ (salt << 16) ^ 32'h5A5A_0000;
   endfunction

   function automatic int nextr();
      seed = seed * 1103515245 + 12345;
      return int'(seed >> 8);
   endfunction

   function automatic int exp_cycles(input logic [L-1:0] m, output bit uni);
      int cnt [L];
      int mx;
      bit first;
      logic [AW-1:0] r;
      mx = 0; first = 1'b1; uni = 1'b1; r = '0;
      for (int b = 0; b < L; b++) cnt[b] = 0;
      for (int t = 0; t < L; t++) begin
         if (m[t]) begin
            if (first) begin r = g_addr[t]; first = 1'b0; end
            else if (g_addr[t] != r) uni = 1'b0;
            cnt[g_addr[t] % 16]++;
         end
      end
      for (int b = 0; b < L; b++) if (cnt[b] > mx) mx = cnt[b];
      if (first || uni) return 1;
      return mx;
   endfunction

   // Runs one group; hold = number of service cycles with a spurious request on the inputs.
   task automatic run_group(input bit wr, input logic [L-1:0] m, input string dtag, input int hold);
      int  k, n;
      bit  uni;
      string ctag;
      k = exp_cycles(m, uni);
      ctag = (m == '0) ? "R5" : (uni ? "R3" : ((k == 1) ? "R2" : "R4"));
      req_valid = 1'b1;
      req_write = wr;
      req_mask  = m;
      for (int t = 0; t < L; t++) begin
         req_addr[t*AW +: AW]  = g_addr[t];
         req_wdata[t*DW +: DW] = g_data[t];
      end
      @(posedge clk);
      @(negedge clk);
      if (hold > 0) begin
         req_write = 1'b1;
         req_mask  = '1;
         for (int t = 0; t < L; t++) req_wdata[t*DW +: DW] = ~g_data[t];
      end else req_valid = 1'b0;
      chk(busy === 1'b1, "R7", "busy after accept", longint'(busy), 1);
      n = 0;
      while (1) begin
         @(posedge clk);
         n++;
         @(negedge clk);
         if (n >= hold) req_valid = 1'b0;
         if (done === 1'b1) break;
         if (n > 64) begin
            chk(1'b0, ctag, "group timeout", n, k);
            break;
         end
      end
      req_valid = 1'b0;
      chk(n == k, ctag, "cycles to done", n, k);
      chk(busy === 1'b0, "R8", "busy low with done", longint'(busy), 0);
      if (wr) begin
         for (int t = 0; t < L; t++) if (m[t]) model[g_addr[t]] = g_data[t];
      end else begin
         for (int t = 0; t < L; t++) if (m[t]) exp_rd[t] = model[g_addr[t]];
      end
      for (int t = 0; t < L; t++) begin
         chk(rd_data[t*DW +: DW] === exp_rd[t], m[t] ? dtag : "R5",
             $sformatf("lane %0d data", t), longint'(rd_data[t*DW +: DW]), longint'(exp_rd[t]));
      end
      @(negedge clk);
      chk(done === 1'b0, "R8", "done is one pulse", longint'(done), 0);
   endtask

   initial begin
      #(8 * 150000);
      chk(1'b0, "R7", "watchdog expired", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      for (int t = 0; t < L; t++) exp_rd[t] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R9: reset state
      chk(busy === 1'b0, "R9", "busy after reset", longint'(busy), 0);
      chk(done === 1'b0, "R9", "done after reset", longint'(done), 0);
      chk(rd_data === '0, "R9", "rd_data after reset", longint'(rd_data[63:0]), 0);

      // R1, R2: fill every word with stride-1 writes
      for (int g = 0; g < 256; g++) begin
         for (int t = 0; t < L; t++) begin
            g_addr[t] = AW'(g * 16 + t);
            g_data[t] = hv(g * 16 + t, 1);
         end
         run_group(1'b1, '1, "R1", 0);
      end

      // R1, R2, R4: stride sweep with several bases
      for (int s = 1; s <= 16; s++) begin
         for (int bi = 0; bi < 3; bi++) begin
            int base;
            base = (bi == 0) ? 0 : ((bi == 1) ? 5 : 1000);
            for (int t = 0; t < L; t++) g_addr[t] = AW'(base + s * t);
            run_group(1'b0, '1, "R1", 0);
         end
      end

      // R2: one-to-one bank permutations with random rows
      for (int p = 0; p < 8; p++) begin
         for (int t = 0; t < L; t++) begin
            int bk;
            bk = ((2 * p + 1) * t + p) % 16;
            g_addr[t] = AW'(((nextr() % 256) * 16) + bk);
         end
         run_group(1'b0, '1, "R2", 0);
      end

      // R3, R5: broadcast reads, inactive lanes pointing elsewhere
      for (int i = 0; i < 6; i++) begin
         logic [L-1:0] m;
         logic [AW-1:0] a;
         m = (i == 0) ? '1 : L'(nextr());
         a = AW'(nextr());
         for (int t = 0; t < L; t++) g_addr[t] = m[t] ? a : AW'(t * 16);
         run_group(1'b0, m, "R3", 0);
      end

      // R6: broadcast write with partial mask, then read the word back
      for (int i = 0; i < 4; i++) begin
         logic [L-1:0] m;
         logic [AW-1:0] a;
         m = L'(16'h00F0 << i) | 16'h0001;
         a = AW'(nextr());
         for (int t = 0; t < L; t++) begin
            g_addr[t] = a;
            g_data[t] = hv(t, 100 + i);
         end
         run_group(1'b1, m, "R6", 0);
         run_group(1'b0, 16'h0004, "R6", 0);
      end

      // R5, R4: masked conflict groups
      for (int i = 0; i < 8; i++) begin
         logic [L-1:0] m;
         m = L'(nextr());
         for (int t = 0; t < L; t++) g_addr[t] = AW'(32 + 8 * t);
         run_group(1'b0, m, "R5", 0);
      end
      run_group(1'b0, '0, "R5", 0);

      // R10: several lanes write one word in a non-uniform group
      for (int i = 0; i < 3; i++) begin
         logic [AW-1:0] a;
         a = AW'(nextr() & 32'hFF0) | AW'(3);
         for (int t = 0; t < L; t++) begin
            g_addr[t] = (t <= 3 + i) ? a : AW'(t + 64 * i);
            g_data[t] = hv(t, 200 + i);
         end
         g_addr[4 + i] = a + AW'(1);
         run_group(1'b1, '1, "R10", 0);
         for (int t = 0; t < L; t++) g_addr[t] = a + AW'(t);
         run_group(1'b0, '1, "R10", 0);
      end

      // R4: shared word but not uniform still costs separate slots
      for (int t = 0; t < L; t++) g_addr[t] = AW'(16 * t + t);
      g_addr[0] = AW'(48); g_addr[1] = AW'(48); g_addr[2] = AW'(49);
      run_group(1'b0, 16'h0007, "R4", 0);

      // R7: spurious request held during a stride-8 group, then read the words it targeted
      for (int t = 0; t < L; t++) begin
         g_addr[t] = AW'(512 + 8 * t);
         g_data[t] = hv(t, 300);
      end
      run_group(1'b0, '1, "R7", 5);
      run_group(1'b0, '1, "R7", 0);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule